// File: doc/BRIEF.md
# UART FIFO Interrupt Status Logic

This block forms the interrupt state for one channel of a multi-channel serial port. It watches the fill counts of the receive and transmit FIFOs and compares them with trigger levels. Each trigger level comes from a 3-bit configuration field scaled by a factor fixed by the channel number. From these comparisons it maintains a four-bit source register, a mask register and the masked pending view. One level-sensitive interrupt line goes high whenever any unmasked source is set.

The block also drives a receive-DMA busy indication. It assembles the FIFO status word and an error-status register for a small register port, and the error-status register clears when read. The FIFO storage, the shift registers and the baud timing live elsewhere and feed this block through its count and flag inputs.

Top module: `uirq_ctrl`

## Requirements
- R1: The trigger factor is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for every other channel. The TX level is `tx_trig` times the factor. The RX level is `rx_trig`+1 times the factor.
- R2: While `fifo_en` is 1, source bit 2 (TX) is set on the next clock edge whenever `tx_count` is less than or equal to the TX level.
- R3: While `fifo_en` is 1, source bit 0 (RX) is set on the next edge when `rx_count` is at least the RX level. It is also set when `rx_count` is non-zero and `timeout_en` is 0.
- R4: While `fifo_en` is 0, source bit 0 is set on the next edge whenever `rx_ready` is 1, and bit 2 is never set by the counts.
- R5: `irq` is 1 exactly when source AND NOT mask is non-zero. A read of address 0 returns that masked pending value in bits 3:0.
- R6: A write to address 0 or address 1 clears the source bits at the 1 positions of `wdata`. A set condition in the same cycle wins over the clear. Address 1 reads the source register.
- R7: A write to address 2 loads the mask from `wdata`, and a read of address 2 returns it.
- R8: `rx_dma_busy` is 1 exactly when `rx_mode` equals 2 and `rx_count` is 0.
- R9: A read of address 3 returns the FIFO status word. Bits 7:0 hold the RX count, or zero when the RX FIFO holds DEPTH entries. Bit 8 is RX full, bit 9 is `rx_err`, bits 23:16 hold the TX count and bit 24 is TX full (count equals DEPTH).
- R10: The error register has bits overrun 0, parity 1, frame 2 and break 3, and collects `err_evt` pulses. A read of address 4 returns it and clears it, keeping only the events of that same cycle. Any other address reads zero.
- R11: After synchronous reset the source, mask and error registers are zero.
- R12: A 1 on any bit of `src_evt` sets the matching source bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_err | input | 1 | Receive FIFO error flag for the status word |
| fifo_en | input | 1 | FIFO mode enable |
| rx_trig | input | 3 | Receive trigger field |
| tx_trig | input | 3 | Transmit trigger field |
| timeout_en | input | 1 | Receive timeout enable |
| rx_mode | input | 2 | Receive transfer mode (2 = DMA) |
| rx_ready | input | 1 | Receive data ready flag (non-FIFO mode) |
| src_evt | input | 4 | Source set pulses |
| err_evt | input | 4 | Error event pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 4 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is 1 |
| irq | output | 1 | Level interrupt |
| rx_dma_busy | output | 1 | Receive DMA busy |

## Verification
The bench runs two instances in parallel, one on channel 1 and one on channel 0. This exposes a wrong channel factor or a missing RX +1 offset as a different threshold crossing, and with it a different `irq` value. Directed steps hit the count exactly at each level. A design comparing with `<` instead of `<=` would miss the TX edge case. A design ignoring `timeout_en` would fire too early. A full RX FIFO must show a zero count field, where a faulty builder shows DEPTH. A clear write that collides with an active set condition must leave the bit set. An error event arriving on the read-clear cycle must survive, and a design that drops it loses the event.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int SRC_W  = 4;
    localparam int LVL_W  = 10;
    localparam int SRC_RX = 0;
    localparam int SRC_TX = 2;

    typedef enum logic [2:0] {
        A_PEND  = 3'd0,
        A_SRC   = 3'd1,
        A_MASK  = 3'd2,
        A_FSTAT = 3'd3,
        A_ERR   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] pad_hi;
        logic       tx_full;
        logic [7:0] tx_cnt;
        logic [5:0] pad_mid;
        logic       rx_err;
        logic       rx_full;
        logic [7:0] rx_cnt;
    } fstat_t;

    function automatic int unsigned trig_factor(input int unsigned ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_trig.sv
module uirq_trig
    import uirq_pkg::*;
#(
    parameter int unsigned CHANNEL = 1
) (
    input  logic [2:0]       rx_trig,
    input  logic [2:0]       tx_trig,
    output logic [LVL_W-1:0] rx_lvl,
    output logic [LVL_W-1:0] tx_lvl
);
    localparam int unsigned FACTOR = trig_factor(CHANNEL);

    always_comb begin
        tx_lvl = LVL_W'(FACTOR) * LVL_W'(tx_trig);
        rx_lvl = LVL_W'(FACTOR) * (LVL_W'(rx_trig) + LVL_W'(1));
    end
endmodule

// File: rtl/uirq_src.sv
module uirq_src
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic             fifo_en,
    input  logic             timeout_en,
    input  logic             rx_ready,
    input  logic [SRC_W-1:0] src_evt,
    output logic [SRC_W-1:0] set_vec
);
    logic rx_hit;
    logic tx_hit;

    always_comb begin
        if (fifo_en) begin
            tx_hit = LVL_W'(tx_count) <= tx_lvl;
            rx_hit = ((rx_count != '0) && !timeout_en) ||
                     (LVL_W'(rx_count) >= rx_lvl);
        end else begin
            tx_hit = 1'b0;
            rx_hit = rx_ready;
        end
        set_vec         = src_evt;
        set_vec[SRC_TX] = src_evt[SRC_TX] | tx_hit;
        set_vec[SRC_RX] = src_evt[SRC_RX] | rx_hit;
    end
endmodule

// File: rtl/uirq_fstat.sv
module uirq_fstat
    import uirq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_err,
    output fstat_t           word
);
    logic rx_full;
    logic tx_full;

    always_comb begin
        rx_full      = rx_count == CNT_W'(DEPTH);
        tx_full      = tx_count == CNT_W'(DEPTH);
        word         = '0;
        word.rx_cnt  = rx_full ? 8'd0 : 8'(rx_count);
        word.rx_full = rx_full;
        word.rx_err  = rx_err;
        word.tx_cnt  = 8'(tx_count);
        word.tx_full = tx_full;
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int unsigned CHANNEL = 1,
    parameter int          DEPTH   = 16,
    localparam int         CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_err,
    input  logic             fifo_en,
    input  logic [2:0]       rx_trig,
    input  logic [2:0]       tx_trig,
    input  logic             timeout_en,
    input  logic [1:0]       rx_mode,
    input  logic             rx_ready,
    input  logic [3:0]       src_evt,
    input  logic [3:0]       err_evt,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [3:0]       wdata,
    output logic [31:0]      rdata,
    output logic             irq,
    output logic             rx_dma_busy
);
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
    logic [SRC_W-1:0] set_vec;
    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] mask_q;
    logic [3:0]       err_q;
    logic [SRC_W-1:0] pend;
    logic [SRC_W-1:0] clr_vec;
    fstat_t           fword;

    uirq_trig #(.CHANNEL(CHANNEL)) u_trig (
        .rx_trig (rx_trig),
        .tx_trig (tx_trig),
        .rx_lvl  (rx_lvl),
        .tx_lvl  (tx_lvl)
    );

    uirq_src #(.CNT_W(CNT_W)) u_src (
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_lvl     (rx_lvl),
        .tx_lvl     (tx_lvl),
        .fifo_en    (fifo_en),
        .timeout_en (timeout_en),
        .rx_ready   (rx_ready),
        .src_evt    (src_evt),
        .set_vec    (set_vec)
    );

    uirq_fstat #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fstat (
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_err   (rx_err),
        .word     (fword)
    );

    always_comb begin
        clr_vec = (wr_en && (addr == A_PEND || addr == A_SRC)) ? wdata : '0;
        pend    = src_q & ~mask_q;
        irq     = |pend;
        rx_dma_busy = (rx_mode == 2'd2) && (rx_count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            mask_q <= '0;
            err_q  <= '0;
        end else begin
            src_q <= (src_q & ~clr_vec) | set_vec;
            if (wr_en && addr == A_MASK) mask_q <= wdata;
            if (rd_en && addr == A_ERR) err_q <= err_evt;
            else                        err_q <= err_q | err_evt;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_PEND:  rdata = 32'(pend);
                A_SRC:   rdata = 32'(src_q);
                A_MASK:  rdata = 32'(mask_q);
                A_FSTAT: rdata = fword;
                A_ERR:   rdata = 32'(err_q);
                default: rdata = '0;
            endcase
        end
    end

    // R2
    tx_level_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && (LVL_W'(tx_count) <= tx_lvl)) |=> src_q[SRC_TX]);
    // R3
    rx_level_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && (LVL_W'(rx_count) >= rx_lvl)) |=> src_q[SRC_RX]);
    // R6
    src_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SRC) |=>
        ((src_q & $past(wdata) & ~$past(set_vec)) == '0));
    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MASK) |=> (mask_q == $past(wdata)));
    // R10
    err_rdclr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_ERR) |=> (err_q == $past(err_evt)));
    // R8
    dma_busy_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_dma_busy |-> (rx_count == '0));
endmodule

// File: tb/tb_uirq_ctrl.sv
module tb_uirq_ctrl;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic          rx_err = 1'b0, fifo_en = 1'b0, timeout_en = 1'b0, rx_ready = 1'b0;
    logic [2:0]    rx_trig = '0, tx_trig = '0, addr = '0;
    logic [1:0]    rx_mode = '0;
    logic [3:0]    src_evt = '0, err_evt = '0, wdata = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]   rdata_a, rdata_b;
    logic          irq_a, irq_b, busy_a, busy_b;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R11";

    int m_src[2], m_mask[2], m_err[2];
    int fac[2] = '{8, 32};

    always #(PERIOD/2) clk = ~clk;

    uirq_ctrl #(.CHANNEL(1), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count), .rx_err(rx_err),
        .fifo_en(fifo_en), .rx_trig(rx_trig), .tx_trig(tx_trig), .timeout_en(timeout_en),
        .rx_mode(rx_mode), .rx_ready(rx_ready), .src_evt(src_evt), .err_evt(err_evt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_a), .irq(irq_a), .rx_dma_busy(busy_a));

    uirq_ctrl #(.CHANNEL(0), .DEPTH(DEPTH)) dut_b (
        .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count), .rx_err(rx_err),
        .fifo_en(fifo_en), .rx_trig(rx_trig), .tx_trig(tx_trig), .timeout_en(timeout_en),
        .rx_mode(rx_mode), .rx_ready(rx_ready), .src_evt(src_evt), .err_evt(err_evt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_b), .irq(irq_b), .rx_dma_busy(busy_b));

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_read(input int k);
        int w, rc, tc;
        rc = int'(rx_count);
        tc = int'(tx_count);
        if (!rd_en) return 0;
        case (int'(addr))
            0: return m_src[k] & ~m_mask[k] & 15;
            1: return m_src[k];
            2: return m_mask[k];
            3: begin
                w = (rc == DEPTH) ? 32'h100 : rc;
                if (rx_err) w |= 32'h200;
                w |= tc << 16;
                if (tc == DEPTH) w |= 32'h0100_0000;
                return w;
            end
            4: return m_err[k];
            default: return 0;
        endcase
    endfunction

    // one clock: check combinational outputs for present inputs, then advance the model
    task automatic cycle();
        int s, lt, lr, c;
        #1;
        for (int k = 0; k < 2; k++) begin
            logic i_act, b_act;
            logic [31:0] r_act;
            i_act = (k == 0) ? irq_a : irq_b;
            b_act = (k == 0) ? busy_a : busy_b;
            r_act = (k == 0) ? rdata_a : rdata_b;
            if (!rst) begin
                chk({"R5/", cur_req, " irq"}, i_act, ((m_src[k] & ~m_mask[k] & 15) != 0));
                chk("R8 dma busy", b_act, (rx_mode == 2'd2 && rx_count == 0));
                if (rd_en) chk({"R9/R10 read ", cur_req}, r_act, exp_read(k));
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_src[k] = 0; m_mask[k] = 0; m_err[k] = 0;
            end else begin
                lt = int'(tx_trig) * fac[k];
                lr = (int'(rx_trig) + 1) * fac[k];
                s = int'(src_evt);
                if (fifo_en) begin
                    if (int'(tx_count) <= lt) s |= 4;
                    if ((rx_count != 0 && !timeout_en) || int'(rx_count) >= lr) s |= 1;
                end else if (rx_ready) s |= 1;
                c = (wr_en && (addr == 0 || addr == 1)) ? int'(wdata) : 0;
                m_src[k] = ((m_src[k] & ~c) | s) & 15;
                if (wr_en && addr == 2) m_mask[k] = int'(wdata);
                if (rd_en && addr == 4) m_err[k] = int'(err_evt);
                else m_err[k] = m_err[k] | int'(err_evt);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; src_evt = 0; err_evt = 0; rx_ready = 0;
    endtask

    task automatic rd(input int a);
        idle(); rd_en = 1; addr = 3'(a); cycle(); rd_en = 0;
    endtask

    task automatic wr(input int a, input int d);
        idle(); wr_en = 1; addr = 3'(a); wdata = 4'(d); cycle(); wr_en = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cycle();
        rst = 0;
        // R11: registers read zero after reset
        cur_req = "R11";
        rd(0); rd(1); rd(2); rd(4);
        // R7: unmask all, read back
        cur_req = "R7";
        wr(2, 0); wr(2, 4'hA); rd(2); wr(2, 0);
        // R2 / R1: TX threshold edge, ch1 level 8 ch0 level 32
        cur_req = "R2";
        fifo_en = 1; tx_trig = 1; rx_trig = 0; timeout_en = 1;
        tx_count = 8; cycle(); cycle(); rd(1);
        wr(1, 4'hF); tx_count = 9; cycle(); cycle(); rd(1);
        tx_trig = 0; tx_count = 1; wr(0, 4'hF); cycle(); rd(1);
        // R3 / R1: RX threshold with timeout enabled, ch1 level 8/16, ch0 32
        cur_req = "R3";
        tx_count = DEPTH; tx_trig = 0;
        wr(1, 4'hF); rx_count = 7; cycle(); rd(1);
        rx_count = 8; cycle(); rd(1); wr(1, 4'hF);
        rx_trig = 1; rx_count = 15; wr(1, 4'hF); cycle(); rd(1);
        rx_count = 16; cycle(); rd(1);
        // R3: count non-zero with timeout disabled
        timeout_en = 0; rx_count = 1; wr(1, 4'hF); cycle(); rd(1);
        // R4: FIFO off, ready flag drives RX bit
        cur_req = "R4";
        fifo_en = 0; rx_count = 0; tx_count = 0; wr(1, 4'hF); cycle(); rd(1);
        idle(); rx_ready = 1; cycle(); rd(1);
        // R6: clear colliding with active set keeps bit
        cur_req = "R6";
        idle(); rx_ready = 1; wr_en = 1; addr = 0; wdata = 4'h1; cycle(); idle(); rd(1);
        // R12: event pulses, R5 masking
        cur_req = "R12";
        wr(1, 4'hF); idle(); src_evt = 4'hA; cycle(); rd(0);
        cur_req = "R5";
        wr(2, 4'h8); rd(0); wr(2, 4'hA); rd(0); wr(0, 4'h2); rd(1); wr(2, 0);
        // R8: DMA busy
        rx_mode = 2; rx_count = 0; cycle(); rx_count = 3; cycle(); rx_mode = 1; rx_count = 0; cycle();
        // R9: status word incl. full forcing count to zero
        cur_req = "R9";
        rx_count = 5; tx_count = 7; rx_err = 1; rd(3);
        rx_count = DEPTH; tx_count = DEPTH; rx_err = 0; rd(3);
        // R10: read clear, same-cycle event retained
        cur_req = "R10";
        idle(); err_evt = 4'h5; cycle(); idle(); rd(4);
        idle(); rd_en = 1; addr = 4; err_evt = 4'h8; cycle(); idle(); rd(4); rd(4); rd(6);
        // mixed traffic
        cur_req = "mix";
        for (int i = 0; i < 4000; i++) begin
            rx_count   = CW'($urandom_range(0, DEPTH));
            tx_count   = CW'($urandom_range(0, DEPTH));
            fifo_en    = ($urandom_range(0, 3) != 0);
            rx_trig    = 3'($urandom);
            tx_trig    = 3'($urandom);
            timeout_en = 1'($urandom);
            rx_mode    = 2'($urandom);
            rx_ready   = 1'($urandom);
            rx_err     = 1'($urandom);
            src_evt    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
            err_evt    = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            wr_en      = ($urandom_range(0, 3) == 0);
            rd_en      = ($urandom_range(0, 2) == 0);
            addr       = 3'($urandom_range(0, 5));
            wdata      = 4'($urandom);
            cycle();
        end
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule